// File: doc/BRIEF.md
# Per-Channel Energy Spectrum Accumulator

This block turns a stream of digitised pulse heights into one energy spectrum for each input channel. Every event carries a channel number and a conversion value. An event is accepted only if three things hold: its value lies inside a programmable lower/upper window, the channel's coincidence gate is open (when gating is enabled), and the channel is not halted. The upper bits of the value select a bin in that channel's bank. The bin counter is then raised by one through a read, add and write sequence.

Each channel has two sticky flags. The half flag records that some bin reached the upper half of the counter range. The full flag records that some bin would have overflowed. A full channel stops acquiring until its flag is cleared, while the other channels carry on. A busy output shows the dead time of the engine. A pulse that fails the gate test raises a one-cycle fast-clear request. Events that arrive during dead time are counted as lost. A simple read port returns any bin, and a clear strobe with per-channel masks resets the flags.

Top module: `hist_accum`

## Requirements
- R1: After reset, busy stays high for exactly NCH*2^BIN_W cycles while every bin is written to zero. All flags, data_ready, fast_clear and lost_count are zero.
- R2: The bin of an event is the upper BIN_W bits of ev_value. Each channel owns a separate bank, so an event changes only bin (ev_chan, value>>(VAL_W-BIN_W)).
- R3: An event with ev_value below lld or above uld (both bounds inclusive in the window) changes no bin, does not raise busy and gives no fast_clear.
- R4: With gate_mode=1, an in-window event whose gate_in[ev_chan] is 0 updates no bin and raises fast_clear for the one cycle after it is presented. With gate_mode=0, gate_in has no effect.
- R5: An accepted event raises busy for exactly three cycles starting the cycle after acceptance. The new bin value can be read once busy falls.
- R6: An event presented while busy is dropped and increments lost_count by one. It changes no bin.
- R7: Incrementing a bin that holds all ones leaves it at all ones and sets full[ev_chan].
- R8: While full[c] is 1, in-window events on channel c change no bin and raise no busy. Other channels keep counting. Clearing full[c] resumes acquisition.
- R9: An increment that moves a bin from 2^(CNT_W-1)-1 to 2^(CNT_W-1) sets half[ev_chan].
- R10: data_ready is 1 exactly when any full or half flag is set. A cycle with clr_en=1 clears the flags selected by clr_full and clr_half from the next cycle on.
- R11: rd_en=1 with rd_chan and rd_bin returns that bin on rd_data in the next cycle, with rd_valid high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present |
| ev_chan | input | CH_W | Event channel |
| ev_value | input | VAL_W | Conversion value |
| lld | input | VAL_W | Lower window bound, inclusive |
| uld | input | VAL_W | Upper window bound, inclusive |
| gate_mode | input | 1 | 1 = per-channel coincidence gating enabled |
| gate_in | input | NCH | Per-channel coincidence gates |
| clr_en | input | 1 | Flag clear strobe |
| clr_full | input | NCH | Full flags to clear |
| clr_half | input | NCH | Half flags to clear |
| rd_en | input | 1 | Bin read request |
| rd_chan | input | CH_W | Channel to read |
| rd_bin | input | BIN_W | Bin to read |
| rd_data | output | CNT_W | Bin contents |
| rd_valid | output | 1 | rd_data valid |
| busy | output | 1 | Engine not ready (dead time) |
| fast_clear | output | 1 | Gate rejection request |
| full | output | NCH | Per-channel full flags |
| half | output | NCH | Per-channel half flags |
| data_ready | output | 1 | Any flag set |
| lost_count | output | LOST_W | Events dropped while busy |

## Verification
A wrong bin address or a lost write does not show at the ports at once. It becomes visible only when the bank is read back, so the bench reads every bin after each sweep and sees a misplaced count within one sweep. A wrong saturation or half-crossing decision shows on the flags and on data_ready in the cycle after the write, well before any readback. Busy-length and lost-counter faults show at the event boundary itself, one to four cycles after the event is presented.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_RD,
    ST_ADD,
    ST_WR
  } eng_state_t;
endpackage

// File: rtl/hist_admit.sv
module hist_admit #(
  parameter int NCH   = 8,
  parameter int VAL_W = 13,
  parameter int CH_W  = 3
) (
  input  logic             busy,
  input  logic             ev_valid,
  input  logic [CH_W-1:0]  ev_chan,
  input  logic [VAL_W-1:0] ev_value,
  input  logic [VAL_W-1:0] lld,
  input  logic [VAL_W-1:0] uld,
  input  logic             gate_mode,
  input  logic [NCH-1:0]   gate_in,
  input  logic [NCH-1:0]   full,
  output logic             take,
  output logic             drop_lost,
  output logic             reject_gate
);
  function automatic logic in_window(input logic [VAL_W-1:0] v,
                                     input logic [VAL_W-1:0] lo,
                                     input logic [VAL_W-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  logic win_ok, gate_ok;
  assign win_ok  = in_window(ev_value, lld, uld);
  assign gate_ok = !gate_mode || gate_in[ev_chan];

  assign drop_lost   = ev_valid && busy;
  assign reject_gate = ev_valid && !busy && win_ok && !gate_ok;
  assign take        = ev_valid && !busy && win_ok && gate_ok && !full[ev_chan];
endmodule

// File: rtl/hist_ram.sv
module hist_ram #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_q
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    a_q <= mem[a_addr];
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/hist_flags.sv
module hist_flags #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_full,
  input  logic [NCH-1:0] set_half,
  input  logic           clr_en,
  input  logic [NCH-1:0] clr_full,
  input  logic [NCH-1:0] clr_half,
  output logic [NCH-1:0] full,
  output logic [NCH-1:0] half,
  output logic           data_ready
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        full[c] <= 1'b0;
        half[c] <= 1'b0;
      end else begin
        if (set_full[c])                full[c] <= 1'b1;
        else if (clr_en && clr_full[c]) full[c] <= 1'b0;
        if (set_half[c])                half[c] <= 1'b1;
        else if (clr_en && clr_half[c]) half[c] <= 1'b0;
      end
    end
  end

  assign data_ready = (|full) || (|half);
endmodule

// File: rtl/hist_accum.sv
module hist_accum
  import hist_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int VAL_W  = 13,
  parameter int BIN_W  = 8,
  parameter int CNT_W  = 32,
  parameter int LOST_W = 16,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [CH_W-1:0]   ev_chan,
  input  logic [VAL_W-1:0]  ev_value,
  input  logic [VAL_W-1:0]  lld,
  input  logic [VAL_W-1:0]  uld,
  input  logic              gate_mode,
  input  logic [NCH-1:0]    gate_in,
  input  logic              clr_en,
  input  logic [NCH-1:0]    clr_full,
  input  logic [NCH-1:0]    clr_half,
  input  logic              rd_en,
  input  logic [CH_W-1:0]   rd_chan,
  input  logic [BIN_W-1:0]  rd_bin,
  output logic [CNT_W-1:0]  rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              fast_clear,
  output logic [NCH-1:0]    full,
  output logic [NCH-1:0]    half,
  output logic              data_ready,
  output logic [LOST_W-1:0] lost_count
);
  localparam int AW = CH_W + BIN_W;
  localparam logic [AW-1:0] LAST_ADDR = AW'((2 ** AW) - 1);
  localparam logic [CNT_W-1:0] ONES = '1;
  localparam logic [CNT_W-1:0] HALF_PT = CNT_W'(1) << (CNT_W - 1);

  // saturating increment of one bin
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == ONES) ? ONES : v + 1'b1;
  endfunction

  // increment moves the bin into the upper half of its range
  function automatic logic half_cross(input logic [CNT_W-1:0] v);
    return (v == HALF_PT - 1'b1);
  endfunction

  eng_state_t state;
  logic [AW-1:0]    addr_q, init_cnt;
  logic [CH_W-1:0]  chan_q;
  logic [CNT_W-1:0] old_q, new_q, ram_a_q;
  logic [LOST_W-1:0] lost_q;
  logic             fc_q, rdv_q;

  // named internal events
  logic take_w, lost_w, reject_w;
  logic wr_cycle, ovf_w, half_w, ram_we;
  logic [AW-1:0]    ram_waddr;
  logic [CNT_W-1:0] ram_wdata;
  logic [NCH-1:0]   set_full_v, set_half_v;

  assign busy = (state != ST_IDLE);

  hist_admit #(.NCH(NCH), .VAL_W(VAL_W), .CH_W(CH_W)) u_admit (
    .busy(busy), .ev_valid(ev_valid), .ev_chan(ev_chan), .ev_value(ev_value),
    .lld(lld), .uld(uld), .gate_mode(gate_mode), .gate_in(gate_in), .full(full),
    .take(take_w), .drop_lost(lost_w), .reject_gate(reject_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_INIT;
      init_cnt <= '0;
      addr_q   <= '0;
      chan_q   <= '0;
      old_q    <= '0;
      new_q    <= '0;
    end else begin
      unique case (state)
        ST_INIT: begin
          init_cnt <= init_cnt + 1'b1;
          if (init_cnt == LAST_ADDR) state <= ST_IDLE;
        end
        ST_IDLE: if (take_w) begin
          state  <= ST_RD;
          chan_q <= ev_chan;
          addr_q <= {ev_chan, ev_value[VAL_W-1 -: BIN_W]};
        end
        ST_RD:  state <= ST_ADD;
        ST_ADD: begin
          old_q <= ram_a_q;
          new_q <= sat_inc(ram_a_q);
          state <= ST_WR;
        end
        ST_WR:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign wr_cycle  = (state == ST_WR);
  assign ovf_w     = wr_cycle && (old_q == ONES);
  assign half_w    = wr_cycle && half_cross(old_q);
  assign ram_we    = (state == ST_INIT) || wr_cycle;
  assign ram_waddr = (state == ST_INIT) ? init_cnt : addr_q;
  assign ram_wdata = (state == ST_INIT) ? '0 : new_q;

  always_comb begin
    set_full_v = '0;
    set_half_v = '0;
    set_full_v[chan_q] = ovf_w;
    set_half_v[chan_q] = half_w;
  end

  hist_ram #(.AW(AW), .DW(CNT_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .a_addr(addr_q), .a_q(ram_a_q),
    .b_addr({rd_chan, rd_bin}), .b_q(rd_data)
  );

  hist_flags #(.NCH(NCH)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_full(set_full_v), .set_half(set_half_v),
    .clr_en(clr_en), .clr_full(clr_full), .clr_half(clr_half),
    .full(full), .half(half), .data_ready(data_ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lost_q <= '0;
      fc_q   <= 1'b0;
      rdv_q  <= 1'b0;
    end else begin
      if (lost_w) lost_q <= lost_q + 1'b1;
      fc_q  <= reject_w;
      rdv_q <= rd_en;
    end
  end

  assign lost_count = lost_q;
  assign fast_clear = fc_q;
  assign rd_valid   = rdv_q;
endmodule

// File: rtl/hist_accum_chk.sv
module hist_accum_chk #(
  parameter int NCH    = 8,
  parameter int CNT_W  = 32,
  parameter int LOST_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              busy,
  input logic              take_w,
  input logic              fast_clear,
  input logic              ovf_w,
  input logic [CNT_W-1:0]  ram_wdata,
  input logic [NCH-1:0]    full,
  input logic [NCH-1:0]    half,
  input logic              data_ready,
  input logic              clr_en,
  input logic [NCH-1:0]    clr_full,
  input logic [LOST_W-1:0] lost_count
);
  // R5: dead time of an accepted event is three cycles
  a_r5_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |=> busy ##1 busy ##1 busy ##1 !busy);

  // R6: an event seen during dead time bumps the lost counter
  a_r6_lost_count: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && busy) |=> lost_count == LOST_W'($past(lost_count) + 1'b1));

  // R4: a fast-clear request never coincides with dead time
  a_r4_fc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fast_clear |-> !busy);

  // R7: overflow writes back a saturated bin
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_w |-> ram_wdata == '1);

  // R8: a full flag only drops through an explicit clear
  a_r8_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(full) & ~($past(clr_en) ? $past(clr_full) : '0)) & ~full) == '0));

  // R10: data_ready mirrors the flag set
  a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready == ((|full) || (|half)));
endmodule

bind hist_accum hist_accum_chk #(.NCH(NCH), .CNT_W(CNT_W), .LOST_W(LOST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .busy(busy), .take_w(take_w),
  .fast_clear(fast_clear), .ovf_w(ovf_w), .ram_wdata(ram_wdata), .full(full),
  .half(half), .data_ready(data_ready), .clr_en(clr_en), .clr_full(clr_full),
  .lost_count(lost_count)
);

// File: tb/sim_hist_accum.sv
module sim_hist_accum;
  localparam int NCH = 4, VAL_W = 6, BIN_W = 4, CNT_W = 4, LOST_W = 8;
  localparam int CH_W = 2, NBIN = 16, DEPTH = 64, CMAX = 15;
  localparam int LO = 4, HI = 59;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [CH_W-1:0] ev_chan = '0;
  logic [VAL_W-1:0] ev_value = '0, lld = VAL_W'(LO), uld = VAL_W'(HI);
  logic gate_mode = 1'b0;
  logic [NCH-1:0] gate_in = '0, clr_full = '0, clr_half = '0;
  logic clr_en = 1'b0, rd_en = 1'b0;
  logic [CH_W-1:0] rd_chan = '0;
  logic [BIN_W-1:0] rd_bin = '0;
  logic [CNT_W-1:0] rd_data;
  logic rd_valid, busy, fast_clear, data_ready;
  logic [NCH-1:0] full, half;
  logic [LOST_W-1:0] lost_count;

  int checks = 0, errors = 0, cycles = 0;
  int m [NCH][NBIN];
  logic [NCH-1:0] mfull = '0, mhalf = '0;
  int mlost = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hist_accum #(.NCH(NCH), .VAL_W(VAL_W), .BIN_W(BIN_W), .CNT_W(CNT_W), .LOST_W(LOST_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_chan(ev_chan), .ev_value(ev_value),
    .lld(lld), .uld(uld), .gate_mode(gate_mode), .gate_in(gate_in), .clr_en(clr_en),
    .clr_full(clr_full), .clr_half(clr_half), .rd_en(rd_en), .rd_chan(rd_chan),
    .rd_bin(rd_bin), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
    .fast_clear(fast_clear), .full(full), .half(half), .data_ready(data_ready),
    .lost_count(lost_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected 0", cycles);
      finish_run();
    end
  end

  // model of one accepted-or-not event; returns whether it is accepted
  function automatic bit model_event(int ch, int v, bit g, output bit fc);
    int b = v >> (VAL_W - BIN_W);
    fc = 0;
    if (v < int'(lld) || v > int'(uld)) return 0;
    if (gate_mode && !g) begin fc = 1; return 0; end
    if (mfull[ch]) return 0;
    if (m[ch][b] == CMAX) mfull[ch] = 1'b1;
    else begin
      if (m[ch][b] == (CMAX + 1) / 2 - 1) mhalf[ch] = 1'b1;
      m[ch][b]++;
    end
    return 1;
  endfunction

  task automatic send(input int ch, input int v, input bit g, input string req);
    bit acc, fc;
    acc = model_event(ch, v, g, fc);
    ev_valid = 1'b1; ev_chan = CH_W'(ch); ev_value = VAL_W'(v);
    gate_in = '0; gate_in[ch] = g;
    @(negedge clk);
    ev_valid = 1'b0;
    chk({req, " busy"}, int'(busy), int'(acc));
    chk({req, " fast_clear"}, int'(fast_clear), int'(fc));
    repeat (3) @(negedge clk);
    chk({req, " idle"}, int'(busy), 0);
  endtask

  task automatic rd(input int ch, input int b, input string req);
    rd_en = 1'b1; rd_chan = CH_W'(ch); rd_bin = BIN_W'(b);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R11 rd_valid", int'(rd_valid), 1);
    chk(req, int'(rd_data), m[ch][b]);
  endtask

  task automatic rd_all(input string req);
    for (int c = 0; c < NCH; c++)
      for (int b = 0; b < NBIN; b++) rd(c, b, req);
  endtask

  task automatic flags(input string req);
    chk({req, " full"}, int'(full), int'(mfull));
    chk({req, " half"}, int'(half), int'(mhalf));
    chk({req, " data_ready"}, int'(data_ready), int'((mfull != 0) || (mhalf != 0)));
    chk({req, " lost"}, int'(lost_count), mlost);
  endtask

  task automatic clear(input logic [NCH-1:0] f, input logic [NCH-1:0] h);
    clr_en = 1'b1; clr_full = f; clr_half = h;
    @(negedge clk);
    clr_en = 1'b0; clr_full = '0; clr_half = '0;
    mfull &= ~f; mhalf &= ~h;
  endtask

  initial begin
    int n;
    for (int c = 0; c < NCH; c++) for (int b = 0; b < NBIN; b++) m[c][b] = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 1);
    rst_n = 1'b1;
    n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
    chk("R1 clear sweep length", n, DEPTH);
    flags("R1");
    chk("R1 fast_clear", int'(fast_clear), 0);
    rd_all("R1 bin zero");

    // ungated sweeps over every value on every channel; gate_in held low (R4 ungated)
    for (int c = 0; c < NCH; c++) for (int v = 0; v < 64; v++) send(c, v, 1'b0, "R3 R5 sweep1");
    rd_all("R2 R3 sweep1 bins");
    flags("R9 after sweep1");
    for (int c = 0; c < NCH; c++) for (int v = 0; v < 64; v++) send(c, v, 1'b0, "R3 R5 sweep2");
    rd_all("R2 sweep2 bins");
    flags("R9 half after sweep2");

    clear('0, 4'b0101);
    flags("R10 partial clear");
    clear('0, 4'b1010);
    flags("R10 all cleared");

    // gated mode
    gate_mode = 1'b1;
    send(1, 20, 1'b0, "R4 gate closed");
    send(1, 20, 1'b1, "R4 gate open");
    send(1, 2, 1'b0, "R3 below window gated");
    rd(1, 5, "R4 gated bin");
    gate_mode = 1'b0;

    // event during dead time
    begin
      bit fcx, acc;
      acc = model_event(3, 30, 1'b0, fcx);
      ev_valid = 1'b1; ev_chan = 2'd3; ev_value = 6'd30;
      @(negedge clk);
      chk("R5 busy after accept", int'(busy), int'(acc));
      @(negedge clk);
      ev_valid = 1'b0;
      mlost++;
      repeat (3) @(negedge clk);
      flags("R6 lost");
      rd(3, 7, "R6 bin once");
    end

    // overflow on channel 2 bin 5
    while (!mfull[2]) send(2, 21, 1'b0, "R7 fill");
    flags("R7 full set");
    rd(2, 5, "R7 saturated");
    send(2, 21, 1'b0, "R8 halted same bin");
    send(2, 40, 1'b0, "R8 halted other bin");
    send(0, 40, 1'b0, "R8 other channel");
    rd(2, 5, "R8 halted bin5");
    rd(2, 10, "R8 halted bin10");
    rd(0, 10, "R8 ch0 bin10");
    clear(4'b0100, '0);
    flags("R10 full cleared");
    send(2, 40, 1'b0, "R8 resumed");
    rd(2, 10, "R8 resumed bin");
    send(3, 63, 1'b0, "R3 above window");
    rd_all("R2 final bins");
    flags("final");
    finish_run();
  end
endmodule